// File: doc/BRIEF.md
# Per-Area Bus Wait-State Sequencer

This block sets the length of each bus access in clock states. When a request arrives, it reads the 3-bit area number and the direction of the access. From these and a small set of configuration inputs it works out three things: the nominal number of states, whether the external active-low WAIT line may stretch the access, and whether the setting is prohibited. It then counts states and raises a done strobe in the state where the access may finish.

Each area is given a kind. A per-area external-select bit chooses between external memory and the area's internal use:

| Area | Internal use |
|------|--------------|
| 1 | DRAM column cycle |
| 5 | on-chip peripheral |
| 6 | address/data multiplexed I/O |
| 0 | on-chip ROM |
| 7 | on-chip RAM |

Areas 2, 3 and 4 are always external memory. External areas 0, 2 and 6 insert a programmable long wait of 1 to 4 states. The other external areas use a short fixed cycle, or a 2-state cycle stretched by WAIT. The whole decision is latched when the access is accepted, so reprogramming during an access has no effect on it.

Top module: `bus_wait_seq`

## Requirements
- R1: A synchronous reset, taken even in the middle of an access, leaves the block idle in the next state: busy low, state count 0, done low.
- R2: A request is taken only while idle. The first state after acceptance shows busy high and count 1. A request held high during an access does not restart it. After done there is always one idle state.
- R3: On-chip ROM (area 0, external-select 0) and on-chip RAM (area 7, external-select 0) take exactly 1 state for reads and writes, and WAIT is ignored.
- R4: A read of external areas 1, 3, 4, 5 or 7 (external-select bit set; ignored for areas 3 and 4) takes exactly 1 state with WAIT ignored when that area's read-wait bit is 0. It takes 2 states plus WAIT stretching when the bit is 1.
- R5: External areas 0, 2 and 6 (the select bit is ignored for area 2) take 1 state plus a long wait of (field+1) states, where long-wait field 00 gives 1 and 11 gives 4. WAIT is honoured on a read only when the area's read-wait bit is 1, and on a write always.
- R6: The DRAM column cycle (area 1, external-select 0) takes 1 state with WAIT ignored when the pitch input is 0. It takes 2 states plus WAIT stretching when the pitch input is 1. This holds for both directions.
- R7: Multiplexed I/O (area 6, external-select 0) takes 4 states plus WAIT stretching. Peripheral space (area 5, external-select 0) takes exactly 3 states with WAIT ignored.
- R8: A write to external areas 3, 4, 5 or 7, or to external area 1 with write-wait mode 1, takes 2 states plus WAIT stretching, whatever the read-wait bits hold.
- R9: A write to external area 1 with write-wait mode 0 is prohibited. It completes in 1 state with the config-error output high in the same state as done.
- R10: WAIT is looked at only from the last nominal state on. Each state in which it is low (asserted) adds one state. Done comes in the first state at or past the nominal length in which WAIT is high. WAIT low in earlier states has no effect.
- R11: Area kind, wait bits, write-wait mode, long-wait field and pitch are captured at acceptance. Changing them during an access leaves its length unchanged.
- R12: The state count equals the number of states elapsed in the access, stepping by one each state, and reads 0 while idle. Done is high only while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_i | input | 1 | synchronous reset, active high |
| req_i | input | 1 | access request, taken while idle |
| area_i | input | 3 | area number of the access |
| wr_i | input | 1 | 1 = write, 0 = read |
| ext_sel_i | input | 8 | per-area kind: 1 = external memory, 0 = internal use |
| rd_wait_en_i | input | 8 | per-area read wait-enable |
| wr_wait_mode_i | input | 1 | write-wait mode for external area 1 |
| long_wait_i | input | LW_W | long-wait field (value+1 states) |
| dram_long_pitch_i | input | 1 | DRAM column cycle pitch: 1 = long |
| wait_n_i | input | 1 | external WAIT, active low |
| busy_o | output | 1 | access in progress |
| state_cnt_o | output | CNT_W | states elapsed in the current access |
| done_o | output | 1 | access may complete in this state |
| cfg_err_o | output | 1 | prohibited setting, high with done |

## Verification
The assertions check on every cycle the counting and handshake rules. These are the gap after done, the first-state count, the step-by-one count and zero while idle, and done never before the nominal length. They also check that done is held back while WAIT is low on an access that honours it, that the error flag appears only with done, and the return to idle after reset. Only the bench's scenarios can show that each area kind, direction and configuration yields the right nominal length and WAIT policy. The same holds for the long-wait encoding, and for changing configuration mid-access leaving the length untouched.

// File: rtl/bws_pkg.sv
package bws_pkg;
   localparam int unsigned NUM_AREAS = 8;
   localparam int unsigned AREA_W    = 3;

   typedef enum logic [2:0] {
      CL_ONCHIP    = 3'd0,
      CL_EXT_PLAIN = 3'd1,
      CL_EXT_LONG  = 3'd2,
      CL_DRAM      = 3'd3,
      CL_MUXIO     = 3'd4,
      CL_PERIPH    = 3'd5
   } area_cls_e;
endpackage

// File: rtl/bws_area_map.sv
module bws_area_map
   import bws_pkg::*;
(
   input  logic [AREA_W-1:0]    area_i,
   input  logic [NUM_AREAS-1:0] ext_sel_i,
   output area_cls_e            cls_o
);
   area_cls_e tab [NUM_AREAS];

   for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
      localparam area_cls_e EXT_C = (g == 0 || g == 2 || g == 6) ? CL_EXT_LONG : CL_EXT_PLAIN;
      localparam area_cls_e INT_C = (g == 1) ? CL_DRAM :
                                    (g == 5) ? CL_PERIPH :
                                    (g == 6) ? CL_MUXIO : CL_ONCHIP;
      if (g >= 2 && g <= 4) begin : g_fixed
         assign tab[g] = EXT_C;
      end else begin : g_sel
         assign tab[g] = ext_sel_i[g] ? EXT_C : INT_C;
      end
   end

   assign cls_o = tab[area_i];
endmodule

// File: rtl/bws_timing_dec.sv
module bws_timing_dec
   import bws_pkg::*;
#(
   parameter int unsigned LW_W  = 2,
   parameter int unsigned CNT_W = 6
) (
   input  area_cls_e          cls_i,
   input  logic [AREA_W-1:0]  area_i,
   input  logic               wr_i,
   input  logic               rd_wait_i,
   input  logic               wr_mode_i,
   input  logic [LW_W-1:0]    long_wait_i,
   input  logic               long_pitch_i,
   output logic [CNT_W-1:0]   len_o,
   output logic               hon_o,
   output logic               err_o
);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);
   localparam logic [CNT_W-1:0] THREE = CNT_W'(3);
   localparam logic [CNT_W-1:0] FOUR  = CNT_W'(4);

   always_comb begin
      len_o = ONE;
      hon_o = 1'b0;
      err_o = 1'b0;
      unique case (cls_i)
         CL_EXT_PLAIN: begin
            if (wr_i) begin
               if (area_i == AREA_W'(1) && !wr_mode_i) begin
                  err_o = 1'b1;
               end else begin
                  len_o = TWO;
                  hon_o = 1'b1;
               end
            end else if (rd_wait_i) begin
               len_o = TWO;
               hon_o = 1'b1;
            end
         end
         CL_EXT_LONG: begin
            len_o = TWO + CNT_W'(long_wait_i);
            hon_o = wr_i | rd_wait_i;
         end
         CL_DRAM: begin
            if (long_pitch_i) begin
               len_o = TWO;
               hon_o = 1'b1;
            end
         end
         CL_MUXIO: begin
            len_o = FOUR;
            hon_o = 1'b1;
         end
         CL_PERIPH: len_o = THREE;
         default: ;
      endcase
   end
endmodule

// File: rtl/bws_seq.sv
module bws_seq #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             req_i,
   input  logic [CNT_W-1:0] len_d_i,
   input  logic             hon_d_i,
   input  logic             err_d_i,
   input  logic             wait_n_i,
   output logic             busy_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             done_o,
   output logic             err_o,
   output logic [CNT_W-1:0] len_q_o,
   output logic             hon_q_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             busy_q, hon_q, err_q;
   logic [CNT_W-1:0] cnt_q, len_q;
   logic             reached, done;

   assign reached = cnt_q >= len_q;
   assign done    = busy_q && reached && (!hon_q || wait_n_i);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         len_q  <= CNT_W'(1);
         hon_q  <= 1'b0;
         err_q  <= 1'b0;
      end else if (!busy_q) begin
         if (req_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
            len_q  <= len_d_i;
            hon_q  <= hon_d_i;
            err_q  <= err_d_i;
         end
      end else if (done) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         err_q  <= 1'b0;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign busy_o  = busy_q;
   assign cnt_o   = cnt_q;
   assign done_o  = done;
   assign err_o   = done && err_q;
   assign len_q_o = len_q;
   assign hon_q_o = hon_q;
endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
   import bws_pkg::*;
#(
   parameter int unsigned LW_W  = 2,
   parameter int unsigned CNT_W = 6
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 req_i,
   input  logic [AREA_W-1:0]    area_i,
   input  logic                 wr_i,
   input  logic [NUM_AREAS-1:0] ext_sel_i,
   input  logic [NUM_AREAS-1:0] rd_wait_en_i,
   input  logic                 wr_wait_mode_i,
   input  logic [LW_W-1:0]      long_wait_i,
   input  logic                 dram_long_pitch_i,
   input  logic                 wait_n_i,
   output logic                 busy_o,
   output logic [CNT_W-1:0]     state_cnt_o,
   output logic                 done_o,
   output logic                 cfg_err_o
);
   localparam int unsigned MAX_NOMINAL = (1 << LW_W) + 1;

   if (LW_W < 1) begin : g_bad_lw
      $error("bus_wait_seq: LW_W must be at least 1");
   end
   if ((1 << CNT_W) <= MAX_NOMINAL + 1) begin : g_bad_cnt
      $error("bus_wait_seq: CNT_W too small for the longest nominal cycle");
   end

   area_cls_e        cls;
   logic [CNT_W-1:0] len_d, seq_len;
   logic             hon_d, err_d, seq_hon;

   bws_area_map map_i (
      .area_i    (area_i),
      .ext_sel_i (ext_sel_i),
      .cls_o     (cls)
   );

   bws_timing_dec #(.LW_W(LW_W), .CNT_W(CNT_W)) dec_i (
      .cls_i        (cls),
      .area_i       (area_i),
      .wr_i         (wr_i),
      .rd_wait_i    (rd_wait_en_i[area_i]),
      .wr_mode_i    (wr_wait_mode_i),
      .long_wait_i  (long_wait_i),
      .long_pitch_i (dram_long_pitch_i),
      .len_o        (len_d),
      .hon_o        (hon_d),
      .err_o        (err_d)
   );

   bws_seq #(.CNT_W(CNT_W)) seq_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .req_i    (req_i),
      .len_d_i  (len_d),
      .hon_d_i  (hon_d),
      .err_d_i  (err_d),
      .wait_n_i (wait_n_i),
      .busy_o   (busy_o),
      .cnt_o    (state_cnt_o),
      .done_o   (done_o),
      .err_o    (cfg_err_o),
      .len_q_o  (seq_len),
      .hon_q_o  (seq_hon)
   );
endmodule

// File: rtl/bus_wait_seq_chk.sv
module bus_wait_seq_chk #(
   parameter int unsigned CNT_W = 6
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             req_i,
   input logic             wait_n_i,
   input logic             busy_i,
   input logic [CNT_W-1:0] cnt_i,
   input logic             done_i,
   input logic             err_i,
   input logic [CNT_W-1:0] len_i,
   input logic             hon_i
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   a_r1_reset_idle: assert property (@(posedge clk_i)
      rst_i |=> (!busy_i && cnt_i == '0 && !done_i));

   a_r2_gap_after_done: assert property (@(posedge clk_i) disable iff (rst_i)
      done_i |=> !busy_i);

   a_r2_first_state: assert property (@(posedge clk_i) disable iff (rst_i)
      (!busy_i && req_i) |=> (busy_i && cnt_i == CNT_W'(1)));

   a_r12_count_step: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_i && !done_i && cnt_i != CNT_MAX) |=> (busy_i && cnt_i == $past(cnt_i) + CNT_W'(1)));

   a_r12_idle_zero: assert property (@(posedge clk_i) disable iff (rst_i)
      !busy_i |-> (cnt_i == '0 && !done_i));

   a_r10_no_early_done: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_i && cnt_i < len_i) |-> !done_i);

   a_r10_wait_holds: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_i && hon_i && !wait_n_i) |-> !done_i);

   a_r9_err_with_done: assert property (@(posedge clk_i) disable iff (rst_i)
      err_i |-> done_i);
endmodule

bind bus_wait_seq bus_wait_seq_chk #(.CNT_W(CNT_W)) chk_i (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .req_i    (req_i),
   .wait_n_i (wait_n_i),
   .busy_i   (busy_o),
   .cnt_i    (state_cnt_o),
   .done_i   (done_o),
   .err_i    (cfg_err_o),
   .len_i    (seq_len),
   .hon_i    (seq_hon)
);

// File: tb/bus_wait_seq_tb.sv
`timescale 1ns/1ps
module bus_wait_seq_tb_top;
   localparam int LW_W  = 2;
   localparam int CNT_W = 6;

   logic             clk = 1'b0;
   logic             rst;
   logic             req;
   logic [2:0]       area;
   logic             wr;
   logic [7:0]       ext_sel;
   logic [7:0]       rwe;
   logic             ww;
   logic [LW_W-1:0]  lw;
   logic             pitch;
   logic             wait_n;
   logic             busy;
   logic [CNT_W-1:0] cnt;
   logic             done;
   logic             cerr;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   bus_wait_seq #(.LW_W(LW_W), .CNT_W(CNT_W)) dut_i (
      .clk_i(clk), .rst_i(rst), .req_i(req), .area_i(area), .wr_i(wr),
      .ext_sel_i(ext_sel), .rd_wait_en_i(rwe), .wr_wait_mode_i(ww),
      .long_wait_i(lw), .dram_long_pitch_i(pitch), .wait_n_i(wait_n),
      .busy_o(busy), .state_cnt_o(cnt), .done_o(done), .cfg_err_o(cerr)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic void model(input logic [2:0] a, input bit w,
                                 output int len, output bit hon, output bit err,
                                 output string tag);
      bit ext = ext_sel[a] || (a == 3'd2) || (a == 3'd3) || (a == 3'd4);
      len = 1; hon = 0; err = 0; tag = "R3";
      if (!ext) begin
         if (a == 3'd1)      begin tag = "R6"; if (pitch) begin len = 2; hon = 1; end end
         else if (a == 3'd5) begin tag = "R7"; len = 3; end
         else if (a == 3'd6) begin tag = "R7"; len = 4; hon = 1; end
      end else if (a == 3'd0 || a == 3'd2 || a == 3'd6) begin
         tag = "R5"; len = 2 + int'(lw); hon = w || rwe[a];
      end else if (w) begin
         if (a == 3'd1 && !ww) begin tag = "R9"; err = 1; end
         else begin tag = "R8"; len = 2; hon = 1; end
      end else begin
         tag = "R4";
         if (rwe[a]) begin len = 2; hon = 1; end
      end
   endfunction

   // WAIT is held low for states 1..wl of the access, high afterwards.
   task automatic access(input logic [2:0] a, input bit w, input int wl,
                         input bit hold, input bit scramble, input string tagx);
      int elen; bit ehon, eerr; string tag; int exp, got, gcnt; bit gerr;
      @(negedge clk);
      area = a; wr = w; req = 1'b1; wait_n = 1'b1;
      model(a, w, elen, ehon, eerr, tag);
      if (tagx != "") tag = tagx;
      exp = eerr ? 1 : (ehon ? ((wl + 1 > elen) ? wl + 1 : elen) : elen);
      @(posedge clk);
      @(negedge clk);
      if (!hold) req = 1'b0;
      if (scramble) begin
         ext_sel = 8'($urandom); rwe = 8'($urandom); ww = 1'($urandom);
         lw = LW_W'($urandom); pitch = 1'($urandom);
      end
      got = 0; gcnt = 0; gerr = 0;
      for (int s = 1; s < 40; s++) begin
         wait_n = (s > wl);
         #1;
         if (!busy) break;
         if (done) begin got = s; gcnt = int'(cnt); gerr = cerr; break; end
         @(negedge clk);
      end
      req = 1'b0;
      chk(got == exp, tag, got, exp);
      chk(gcnt == got, {tag, " R12 count"}, gcnt, got);
      chk(gerr == eerr, {tag, " err"}, int'(gerr), int'(eerr));
      @(negedge clk);
      #1;
      chk(!busy && cnt == 0, "R2 idle gap", int'(busy), 0);
   endtask

   initial begin
      #(5.0 * 150000);
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst = 1; req = 0; area = 0; wr = 0; ext_sel = 0; rwe = 0; ww = 0;
      lw = 0; pitch = 0; wait_n = 1;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk(!busy && cnt == 0 && !done && !cerr, "R1 reset state", int'(busy), 0);
      rst = 0;

      // R3 on-chip ROM / RAM
      ext_sel = 8'h00;
      access(3'd0, 0, 5, 0, 0, "R3 rom");
      access(3'd7, 1, 3, 0, 0, "R3 ram");
      // R4 external plain reads
      ext_sel = 8'hFF; rwe = 8'h00;
      access(3'd3, 0, 4, 0, 0, "R4 nowait");
      rwe = 8'hFF;
      access(3'd3, 0, 0, 0, 0, "R4 wait0");
      access(3'd7, 0, 4, 0, 0, "R4 wait4");
      // R10 WAIT low only before the last nominal state
      access(3'd5, 0, 1, 0, 0, "R10 early");
      // R5 long-wait encoding
      rwe = 8'h00;
      for (int k = 0; k < 4; k++) begin
         lw = LW_W'(k);
         access(3'd2, 0, 6, 0, 0, "R5 long");
      end
      lw = 2'd1;
      access(3'd6, 1, 5, 0, 0, "R5 write wait");
      rwe = 8'hFF; lw = 2'd2;
      access(3'd0, 0, 2, 0, 0, "R10 long early");
      // R6 DRAM
      ext_sel = 8'h00; pitch = 0;
      access(3'd1, 0, 3, 0, 0, "R6 short");
      pitch = 1;
      access(3'd1, 1, 3, 0, 0, "R6 long");
      // R7 mux I/O and peripheral
      access(3'd6, 0, 0, 0, 0, "R7 mux");
      access(3'd6, 1, 6, 0, 0, "R7 mux wait");
      access(3'd5, 0, 5, 0, 0, "R7 periph");
      // R8 writes
      ext_sel = 8'hFF; rwe = 8'h00; ww = 1;
      access(3'd4, 1, 2, 0, 0, "R8 area4");
      access(3'd1, 1, 0, 0, 0, "R8 area1");
      // R9 prohibited
      ww = 0;
      access(3'd1, 1, 4, 0, 0, "R9 prohibited");
      // R11 config change mid-access
      lw = 2'd3; rwe = 8'h00;
      access(3'd2, 0, 0, 0, 1, "R11 latch");
      ext_sel = 8'h00;
      access(3'd6, 0, 2, 0, 1, "R11 latch mux");
      // R2 request held through the access
      ext_sel = 8'h00;
      access(3'd5, 0, 0, 1, 0, "R2 held req");

      // R1 reset in the middle of an access
      @(negedge clk);
      area = 3'd6; wr = 0; req = 1; wait_n = 0;
      @(posedge clk); @(negedge clk); req = 0;
      @(negedge clk); rst = 1;
      @(posedge clk); @(negedge clk); #1;
      chk(!busy && cnt == 0 && !done, "R1 mid-access reset", int'(busy), 0);
      rst = 0; wait_n = 1;

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         ext_sel = 8'($urandom); rwe = 8'($urandom); ww = 1'($urandom);
         lw = LW_W'($urandom); pitch = 1'($urandom);
         access(3'($urandom), 1'($urandom), int'($urandom_range(0, 7)),
                1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0), "");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule